// File: doc/BRIEF.md
# Serial Configuration Loader

This block takes the configuration words that a host sends over three slow pins (a serial clock, a data line and a load strobe) and places them into the control registers of a frequency-synthesizer core. Every word is 24 bits long and arrives with its most significant bit first. The two bits that arrive last in a word are a destination code. When the load strobe rises, the 22 bits of payload that sit above the code are copied into the register that the code selects. The divider and detector logic read the latched payloads directly. Each one comes with a strobe that lasts one cycle, so the consumer knows a new value has arrived.

All three pins are sampled by a fast system clock. Each pin passes through a two-flop synchronizer and an edge detector. A small state machine handles the load strobe. It has three states:
- `ST_SHIFT`: accepts serial clock edges.
- `ST_COMMIT`: lasts one cycle, during which the destination register is written.
- `ST_HOLD`: waits for the strobe to fall and ignores serial clock edges meanwhile.

The transitions are:
- `ST_SHIFT` to `ST_COMMIT` on a strobe rise.
- `ST_COMMIT` to `ST_HOLD` while the strobe is still high, or back to `ST_SHIFT` if it has already dropped.
- `ST_HOLD` to `ST_SHIFT` when the strobe falls.

A word with the code for the initialization target also reloads the function register and sends a one-cycle reset pulse to the counters.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, all three latched words read zero and no strobe or counter-reset pulse is active.
- R2: Each synchronized rising edge of `ser_clk` shifts `ser_data` into a 24-bit register, most significant bit first. A latched payload equals bits 23..2 of the last word shifted in.
- R3: Destination code 2'b00 (word bits 1..0) writes the payload to `ref_word`. It pulses `ref_upd`, and the other words stay unchanged.
- R4: Code 2'b01 writes the payload to `ndiv_word` and pulses `ndiv_upd`. The other words stay unchanged.
- R5: Code 2'b10 writes the payload to `func_word` and pulses `func_upd`. No counter-reset pulse is produced.
- R6: Code 2'b11 writes the payload to `func_word`. It pulses both `func_upd` and `cnt_rst`, and leaves `ref_word` and `ndiv_word` unchanged.
- R7: One load-strobe pulse, however long it is held, gives exactly one update strobe, which lasts one cycle. At most one of the three update strobes is high at a time.
- R8: Serial clock edges that arrive while the load strobe is high do not change the shift register.
- R9: When more than 24 bits are shifted in before a load, only the last 24 bits count.
- R10: The update strobe is high in the fourth system-clock cycle after the first rising edge that samples the load pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_le | input | 1 | Load strobe pin |
| ref_word | output | 22 | Latched reference-counter payload |
| ndiv_word | output | 22 | Latched N-counter payload |
| func_word | output | 22 | Latched function payload |
| ref_upd | output | 1 | One-cycle strobe when `ref_word` is written |
| ndiv_upd | output | 1 | One-cycle strobe when `ndiv_word` is written |
| func_upd | output | 1 | One-cycle strobe when `func_word` is written |
| cnt_rst | output | 1 | One-cycle counter-reset pulse on an initialization write |

## Verification
A state machine stuck in `ST_SHIFT` while the strobe is high lets stray serial clocks shift the word. The damage shows on the next load: either the wrong register receives the word, or it receives shifted data. A wrong decode or a missed commit shows within four cycles of the strobe rise, as a missing or misplaced update strobe or as an unchanged latched word. A strobe that repeats or lasts too long shows as an extra pulse while the load pin is still held.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int unsigned CTRL_W = 2;

    typedef enum logic [CTRL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } ld_state_e;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], pin};
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cfg_shift_fsm.sv
module cfg_shift_fsm
    import cfg_loader_pkg::*;
#(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sdata,
    input  logic              le_lvl,
    input  logic              le_rise,
    output logic [WORD_W-1:0] word,
    output logic              commit
);
    ld_state_e         state, state_nx;
    logic [WORD_W-1:0] shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SHIFT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT:  if (le_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = le_lvl ? ST_HOLD : ST_SHIFT;
            ST_HOLD:   if (!le_lvl) state_nx = ST_SHIFT;
            default:   state_nx = ST_SHIFT;
        endcase
    end

    // outputs: the shift register moves only in ST_SHIFT, and a strobe rise takes priority over a clock edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (state == ST_SHIFT && !le_rise && sclk_rise)
            shreg <= {shreg[WORD_W-2:0], sdata};
    end

    assign word   = shreg;
    assign commit = (state == ST_COMMIT);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> $stable(shreg));
    p_commit_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> ($past(state) == ST_SHIFT));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_loader_pkg::*;
#(
    parameter int unsigned WORD_W = 24,
    localparam int unsigned PAY_W = WORD_W - CTRL_W,
    localparam int unsigned N_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [PAY_W-1:0]  ref_q,
    output logic [PAY_W-1:0]  ndiv_q,
    output logic [PAY_W-1:0]  func_q,
    output logic              upd_ref,
    output logic              upd_ndiv,
    output logic              upd_func,
    output logic              cnt_rst
);
    sel_e             sel;
    logic [N_LAT-1:0] wr;
    logic [N_LAT-1:0] upd;
    logic [PAY_W-1:0] lat [N_LAT];

    assign sel   = sel_e'(word[CTRL_W-1:0]);
    assign wr[0] = (sel == SEL_REF);
    assign wr[1] = (sel == SEL_NDIV);
    assign wr[2] = (sel == SEL_FUNC) || (sel == SEL_INIT);

    for (genvar g = 0; g < N_LAT; g++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lat[g] <= '0;
            else if (commit && wr[g])
                lat[g] <= word[WORD_W-1:CTRL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd     <= '0;
            cnt_rst <= 1'b0;
        end else begin
            upd     <= commit ? wr : '0;
            cnt_rst <= commit && (sel == SEL_INIT);
        end
    end

    assign ref_q    = lat[0];
    assign ndiv_q   = lat[1];
    assign func_q   = lat[2];
    assign upd_ref  = upd[0];
    assign upd_ndiv = upd[1];
    assign upd_func = upd[2];

    p_ref_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != $past(ref_q)) |-> upd_ref);
    p_ndiv_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ndiv_q != $past(ndiv_q)) |-> upd_ndiv);
    p_init_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |-> upd_func);
    p_one_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_ref, upd_ndiv, upd_func}));
    p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_func |=> !upd_func);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned WORD_W      = 24,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PAY_W      = WORD_W - CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [PAY_W-1:0] ref_word,
    output logic [PAY_W-1:0] ndiv_word,
    output logic [PAY_W-1:0] func_word,
    output logic             ref_upd,
    output logic             ndiv_upd,
    output logic             func_upd,
    output logic             cnt_rst
);
    localparam int unsigned N_PIN = 3;

    logic [N_PIN-1:0] pins, lvls, rises;
    logic [WORD_W-1:0] word;
    logic              commit;

    assign pins = {ser_le, ser_data, ser_clk};

    for (genvar p = 0; p < N_PIN; p++) begin : g_sync
        cfg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[p]),
            .lvl  (lvls[p]),
            .rise (rises[p])
        );
    end

    cfg_shift_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(rises[0]),
        .sdata    (lvls[1]),
        .le_lvl   (lvls[2]),
        .le_rise  (rises[2]),
        .word     (word),
        .commit   (commit)
    );

    cfg_latch_bank #(.WORD_W(WORD_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .word    (word),
        .ref_q   (ref_word),
        .ndiv_q  (ndiv_word),
        .func_q  (func_word),
        .upd_ref (ref_upd),
        .upd_ndiv(ndiv_upd),
        .upd_func(func_upd),
        .cnt_rst (cnt_rst)
    );
endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [21:0] ref_word, ndiv_word, func_word;
    logic ref_upd, ndiv_upd, func_upd, cnt_rst;

    int checks = 0, errors = 0;
    int n_ref, n_ndiv, n_func, n_rst, first;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_word(ref_word), .ndiv_word(ndiv_word), .func_word(func_word),
        .ref_upd(ref_upd), .ndiv_upd(ndiv_upd), .func_upd(func_upd), .cnt_rst(cnt_rst)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk) ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
    endtask

    // raises the load pin, counts every strobe over the window, drops it after HOLD cycles
    task automatic le_pulse();
        n_ref = 0; n_ndiv = 0; n_func = 0; n_rst = 0; first = -1;
        @(negedge clk) ser_le = 1'b1;
        for (int c = 1; c <= HOLD + 8; c++) begin
            @(posedge clk); #1;
            n_ref  += ref_upd;
            n_ndiv += ndiv_upd;
            n_func += func_upd;
            n_rst  += cnt_rst;
            if ((ref_upd || ndiv_upd || func_upd) && first < 0) first = c;
            if (c == HOLD) ser_le = 1'b0;
        end
    endtask

    task automatic t_reset();
        check(ref_word == 0 && ndiv_word == 0 && func_word == 0, "R1 words", {10'b0, ref_word}, 0);
        check(!ref_upd && !ndiv_upd && !func_upd && !cnt_rst, "R1 strobes",
              {28'b0, ref_upd, ndiv_upd, func_upd, cnt_rst}, 0);
    endtask

    task automatic t_ref();
        logic [23:0] w = {22'h2B3C5D, 2'b00};
        shift_bits({8'b0, w}, 24);
        le_pulse();
        check(ref_word == w[23:2], "R2/R3 ref payload", {10'b0, ref_word}, {10'b0, w[23:2]});
        check(n_ref == 1 && n_ndiv == 0 && n_func == 0, "R3/R7 ref strobe count", n_ref, 1);
        check(first == 4, "R10 strobe latency", first, 4);
        check(ndiv_word == 0 && func_word == 0, "R3 others untouched", {10'b0, ndiv_word}, 0);
    endtask

    task automatic t_ndiv();
        logic [23:0] w = {22'h15A5A6, 2'b01};
        shift_bits({8'b0, w}, 24);
        le_pulse();
        check(ndiv_word == w[23:2], "R4 ndiv payload", {10'b0, ndiv_word}, {10'b0, w[23:2]});
        check(n_ndiv == 1 && n_ref == 0 && n_func == 0, "R4/R7 ndiv strobe", n_ndiv, 1);
        check(ref_word == 22'h2B3C5D, "R4 ref kept", {10'b0, ref_word}, 32'h2B3C5D);
    endtask

    task automatic t_func();
        logic [23:0] w = {22'h3F0F01, 2'b10};
        shift_bits({8'b0, w}, 24);
        le_pulse();
        check(func_word == w[23:2], "R5 func payload", {10'b0, func_word}, {10'b0, w[23:2]});
        check(n_func == 1 && n_rst == 0, "R5 no counter reset", n_rst, 0);
    endtask

    task automatic t_init();
        logic [23:0] w = {22'h0C3A97, 2'b11};
        shift_bits({8'b0, w}, 24);
        le_pulse();
        check(func_word == w[23:2], "R6 init to func", {10'b0, func_word}, {10'b0, w[23:2]});
        check(n_rst == 1 && n_func == 1, "R6 counter reset pulse", n_rst, 1);
        check(ndiv_word == 22'h15A5A6 && ref_word == 22'h2B3C5D, "R6 others kept",
              {10'b0, ndiv_word}, 32'h15A5A6);
    endtask

    task automatic t_ignore();
        logic [23:0] w = {22'h1E2D3C, 2'b00};
        shift_bits({8'b0, w}, 24);
        le_pulse();
        // clock six ones while the load pin is held high
        @(negedge clk) ser_le = 1'b1;
        repeat (6) ser_bit(1'b1);
        @(negedge clk) ser_le = 1'b0;
        repeat (6) @(negedge clk);
        le_pulse();
        check(ref_word == w[23:2], "R8 word kept under LE", {10'b0, ref_word}, {10'b0, w[23:2]});
        check(n_ref == 1 && n_rst == 0 && n_func == 0, "R8 same destination", n_ref, 1);
    endtask

    task automatic t_long();
        logic [23:0] w = {22'h3A5011, 2'b01};
        shift_bits({8'b0, 6'b111111, w[23:0]} , 30);
        le_pulse();
        check(ndiv_word == w[23:2], "R9 last 24 bits", {10'b0, ndiv_word}, {10'b0, w[23:2]});
        check(n_ndiv == 1 && n_func == 0, "R9 destination", n_ndiv, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_ref();
        t_ndiv();
        t_func();
        t_init();
        t_ignore();
        t_long();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule